// File: doc/BRIEF.md
# Shared-RAM Host Access Port

This block lets a host processor reach a byte-wide RAM that it shares with an attached coprocessor. The host sees four byte registers selected by a two-bit index. Two of them hold the low and high bytes of a 16-bit pointer into the RAM. The third is a data window that moves one byte at the pointer. The fourth holds the run and interrupt controls. When auto-increment is on, every data-window access moves the pointer forward by one. A whole block can then be streamed after a single pointer load.

The coprocessor side is a plain memory port plus three event strobes. Two of the strobes raise mailbox flags toward the host. The third acknowledges the host's request. The two mailbox flags share one host interrupt line, and the host clears them by writing ones. The same control write also carries the run and auto-increment settings, so the host rewrites those bits each time to keep them set. Software can use a fixed RAM byte as a liveness marker: the coprocessor stores 0xFF there, and the host reads it back and writes zero.

Top module: `shram_host_port`

## Requirements
- R1: After a synchronous active-low reset, the pointer, all control bits, both mailbox flags, `host_rdata`, `host_irq`, `cop_run` and `cop_irq` are zero.
- R2: A write with `host_reg`=0 loads pointer bits 7:0 and a write with `host_reg`=1 loads bits 15:8. Reads of those indices return the same bytes.
- R3: A write with `host_reg`=2 stores the byte in RAM, and a read with `host_reg`=2 returns it. The RAM location is the low RAM_AW bits of the pointer.
- R4: With auto-increment set, each data-window read or write advances the pointer by one after the access. The pointer wraps from 0xFFFF to 0x0000.
- R5: With auto-increment clear, data-window accesses leave the pointer unchanged.
- R6: Control byte (`host_reg`=3) layout: bit0 INT0, bit1 INT1, bit2 RUN, bit3 IRQ, bit4 AUTOINC, bits 7:5 read zero. A control write loads RUN and AUTOINC, and `cop_run` follows RUN.
- R7: A control write with bit3 set raises `cop_irq`. `cop_irq_ack` clears it. If both happen in the same cycle, the write wins.
- R8: `cop_set_int0` and `cop_set_int1` set INT0 and INT1. `host_irq` is high while either flag is set.
- R9: A control write with a one in bit0 or bit1 clears only that flag, and a zero there leaves the flag unchanged. If a set strobe and a clearing write hit the same flag in the same cycle, the flag stays set.
- R10: The coprocessor port reads and writes the same RAM. `cop_rdata` is registered one cycle after a read strobe. A host write and a coprocessor write on the same cycle to the same byte leave the host's value.
- R11: A host read updates `host_rdata` at the next clock edge. The value then holds until the next host read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_reg | input | 2 | Register index: 0 ptr low, 1 ptr high, 2 data, 3 control |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| host_irq | output | 1 | Host interrupt, OR of the two mailbox flags |
| cop_en | input | 1 | Coprocessor memory access strobe |
| cop_we | input | 1 | Coprocessor write enable |
| cop_addr | input | RAM_AW | Coprocessor RAM address |
| cop_wdata | input | 8 | Coprocessor write byte |
| cop_rdata | output | 8 | Registered coprocessor read byte |
| cop_set_int0 | input | 1 | Coprocessor strobe that sets INT0 |
| cop_set_int1 | input | 1 | Coprocessor strobe that sets INT1 |
| cop_irq_ack | input | 1 | Coprocessor acknowledge of the host request |
| cop_run | output | 1 | Run enable toward the coprocessor |
| cop_irq | output | 1 | Host-to-coprocessor request |

## Verification
The checker watches several rules on every cycle:
- pointer stepping and holding around data-window accesses;
- the set and acknowledge rules for the coprocessor request, including the write-wins collision;
- clearing of INT0 by a one and the set-over-clear collision;
- the interrupt line following a mailbox set;
- RUN tracking the last control write.

Some behaviour needs a sequence of accesses, so only the bench's scenarios can show it:
- the data that round-trips through the RAM;
- address aliasing into the smaller array;
- the 0xFFFF wrap as seen through register readback;
- the liveness-byte handshake between the two sides;
- the exact control byte layout.

// File: rtl/shram_pkg.sv
// Shared definitions for the shared-RAM host access port.
// Assumes a byte-wide host register file with four registers.
package shram_pkg;
    typedef enum logic [1:0] {
        REG_PTR_LO = 2'd0,
        REG_PTR_HI = 2'd1,
        REG_DATA   = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    localparam int BIT_INT0 = 0;
    localparam int BIT_INT1 = 1;
    localparam int BIT_RUN  = 2;
    localparam int BIT_IRQ  = 3;
    localparam int BIT_AUTO = 4;

    // Field order makes int0 land on bit 0 when packed.
    typedef struct packed {
        logic autoinc;
        logic irq;
        logic run;
        logic int1;
        logic int0;
    } ctrl_t;
endpackage

// File: rtl/shram_ptr_reg.sv
// Pointer register: two byte-loadable halves plus an increment step.
// Assumes at most one of ld_lo, ld_hi, step is active per cycle;
// the caller guarantees this by decoding one register index.
module shram_ptr_reg #(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              step,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] ptr
);
    // Load either half or advance with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ld_lo) begin
            ptr[DATA_W-1:0] <= wdata;
        end else if (ld_hi) begin
            ptr[ADDR_W-1:DATA_W] <= wdata;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/shram_ctrl_regs.sv
// Run/request/mailbox control bits.
// Set events from the coprocessor win over host write-one clears;
// a host request write wins over a same-cycle acknowledge.
module shram_ctrl_regs
    import shram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_int0,
    input  logic              set_int1,
    input  logic              irq_ack,
    output ctrl_t             st
);
    // Run and auto-increment follow each control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.run     <= 1'b0;
            st.autoinc <= 1'b0;
        end else if (ctrl_wr) begin
            st.run     <= wdata[BIT_RUN];
            st.autoinc <= wdata[BIT_AUTO];
        end
    end

    // Host request: set by write, dropped by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.irq <= 1'b0;
        end else if (ctrl_wr && wdata[BIT_IRQ]) begin
            st.irq <= 1'b1;
        end else if (irq_ack) begin
            st.irq <= 1'b0;
        end
    end

    // INT0 mailbox flag, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.int0 <= 1'b0;
        end else if (set_int0) begin
            st.int0 <= 1'b1;
        end else if (ctrl_wr && wdata[BIT_INT0]) begin
            st.int0 <= 1'b0;
        end
    end

    // INT1 mailbox flag, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.int1 <= 1'b0;
        end else if (set_int1) begin
            st.int1 <= 1'b1;
        end else if (ctrl_wr && wdata[BIT_INT1]) begin
            st.int1 <= 1'b0;
        end
    end
endmodule

// File: rtl/shram_mem.sv
// Behavioural two-port byte RAM.
// The host port reads combinationally; the coprocessor port reads
// registered. On a same-address double write the host port wins.
module shram_mem #(
    parameter int AW = 8,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          c_en,
    input  logic          c_we,
    input  logic [AW-1:0] c_addr,
    input  logic [DW-1:0] c_wdata,
    output logic [DW-1:0] c_rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Array writes; host assignment last so it takes precedence.
    always_ff @(posedge clk) begin
        if (c_en && c_we) begin
            mem[c_addr] <= c_wdata;
        end
        if (h_we) begin
            mem[h_addr] <= h_wdata;
        end
    end

    // Registered coprocessor read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_rdata <= '0;
        end else if (c_en && !c_we) begin
            c_rdata <= mem[c_addr];
        end
    end

    // Host read path feeds the top-level read register.
    assign h_rdata = mem[h_addr];
endmodule

// File: rtl/shram_host_port.sv
// Host access port into a RAM shared with a coprocessor.
// Decodes the four host registers, registers host read data, and drives
// the coprocessor control outputs. Assumes single-cycle access strobes;
// if host_wr and host_rd coincide, the pointer still steps only once.
module shram_host_port
    import shram_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RAM_AW = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_reg,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_irq,
    input  logic              cop_en,
    input  logic              cop_we,
    input  logic [RAM_AW-1:0] cop_addr,
    input  logic [DATA_W-1:0] cop_wdata,
    output logic [DATA_W-1:0] cop_rdata,
    input  logic              cop_set_int0,
    input  logic              cop_set_int1,
    input  logic              cop_irq_ack,
    output logic              cop_run,
    output logic              cop_irq
);
    localparam int ST_W = $bits(ctrl_t);

    reg_sel_e          sel;
    logic [ADDR_W-1:0] ptr;
    ctrl_t             st;
    logic [DATA_W-1:0] mem_rd;
    logic              data_acc;
    logic              data_wr;
    logic              ctrl_wr;

    assign sel      = reg_sel_e'(host_reg);
    assign data_acc = (host_wr || host_rd) && (sel == REG_DATA);
    assign data_wr  = host_wr && (sel == REG_DATA);
    assign ctrl_wr  = host_wr && (sel == REG_CTRL);

    shram_ptr_reg #(.DATA_W(DATA_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (host_wr && (sel == REG_PTR_LO)),
        .ld_hi (host_wr && (sel == REG_PTR_HI)),
        .step  (data_acc && st.autoinc),
        .wdata (host_wdata),
        .ptr   (ptr)
    );

    shram_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .wdata    (host_wdata),
        .set_int0 (cop_set_int0),
        .set_int1 (cop_set_int1),
        .irq_ack  (cop_irq_ack),
        .st       (st)
    );

    shram_mem #(.AW(RAM_AW), .DW(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (data_wr),
        .h_addr  (ptr[RAM_AW-1:0]),
        .h_wdata (host_wdata),
        .h_rdata (mem_rd),
        .c_en    (cop_en),
        .c_we    (cop_we),
        .c_addr  (cop_addr),
        .c_wdata (cop_wdata),
        .c_rdata (cop_rdata)
    );

    // Capture the selected register on a host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            unique case (sel)
                REG_PTR_LO: host_rdata <= ptr[DATA_W-1:0];
                REG_PTR_HI: host_rdata <= ptr[ADDR_W-1:DATA_W];
                REG_DATA:   host_rdata <= mem_rd;
                REG_CTRL:   host_rdata <= {{(DATA_W-ST_W){1'b0}}, st};
                default:    host_rdata <= '0;
            endcase
        end
    end

    assign host_irq = st.int0 | st.int1;
    assign cop_run  = st.run;
    assign cop_irq  = st.irq;
endmodule

// File: rtl/shram_host_port_chk.sv
// Cycle-level checker for the shared-RAM host access port, bound to the top.
module shram_host_port_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [1:0]        host_reg,
    input logic [7:0]        host_wdata,
    input logic              host_irq,
    input logic              cop_set_int0,
    input logic              cop_irq_ack,
    input logic              cop_run,
    input logic              cop_irq,
    input logic              auto_on,
    input logic              int0_q,
    input logic [ADDR_W-1:0] ptr
);
    logic data_acc;
    logic ctrl_wr;

    assign data_acc = (host_wr || host_rd) && (host_reg == 2'd2);
    assign ctrl_wr  = host_wr && (host_reg == 2'd3);

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && auto_on) |=> (ptr == $past(ptr) + 1'b1)); // R4

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !auto_on) |=> $stable(ptr)); // R5

    AST_RUN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (cop_run == $past(host_wdata[2]))); // R6

    AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && host_wdata[3]) |=> cop_irq); // R7

    AST_REQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_irq_ack && !(ctrl_wr && host_wdata[3])) |=> !cop_irq); // R7

    AST_LINE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        cop_set_int0 |=> host_irq); // R8

    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && host_wdata[0] && !cop_set_int0) |=> !int0_q); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && host_wdata[0] && cop_set_int0) |=> int0_q); // R9
endmodule

bind shram_host_port shram_host_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_reg     (host_reg),
    .host_wdata   (host_wdata),
    .host_irq     (host_irq),
    .cop_set_int0 (cop_set_int0),
    .cop_irq_ack  (cop_irq_ack),
    .cop_run      (cop_run),
    .cop_irq      (cop_irq),
    .auto_on      (st.autoinc),
    .int0_q       (st.int0),
    .ptr          (ptr)
);

// File: tb/tb_shram_host_port.sv
// Directed bench for the shared-RAM host access port.
module tb_shram_host_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_reg = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_irq;
    logic       cop_en = 1'b0, cop_we = 1'b0;
    logic [7:0] cop_addr = '0, cop_wdata = '0;
    logic [7:0] cop_rdata;
    logic       cop_set_int0 = 1'b0, cop_set_int1 = 1'b0, cop_irq_ack = 1'b0;
    logic       cop_run, cop_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shram_host_port dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] r, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_reg = r; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] r, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_reg = r;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic set_ptr(input logic [15:0] a);
        hwrite(2'd0, a[7:0]);
        hwrite(2'd1, a[15:8]);
    endtask

    task automatic cwrite(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cop_en = 1'b1; cop_we = 1'b1; cop_addr = a; cop_wdata = d;
        @(negedge clk);
        cop_en = 1'b0; cop_we = 1'b0;
    endtask

    task automatic cread(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cop_en = 1'b1; cop_we = 1'b0; cop_addr = a;
        @(negedge clk);
        cop_en = 1'b0;
        d = cop_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 host_rdata", host_rdata, 0);
        chk("R1 host_irq", host_irq, 0);
        chk("R1 cop_run", cop_run, 0);
        chk("R1 cop_irq", cop_irq, 0);
        hread(2'd3, v); chk("R1 ctrl", v, 0);
        hread(2'd1, v); chk("R1 ptr hi", v, 0);
    endtask

    task automatic t_ptr_load();
        logic [7:0] v;
        set_ptr(16'h1234);
        hread(2'd0, v); chk("R2 ptr lo", v, 8'h34);
        hread(2'd1, v); chk("R2 ptr hi", v, 8'h12);
    endtask

    task automatic t_data_noinc();
        logic [7:0] v;
        set_ptr(16'h0010);
        hwrite(2'd2, 8'hA5);
        hread(2'd0, v); chk("R5 ptr after write", v, 8'h10);
        hread(2'd2, v); chk("R3 data readback", v, 8'hA5);
        @(negedge clk); host_reg = 2'd0;
        @(negedge clk); chk("R11 rdata holds", host_rdata, 8'hA5);
        hread(2'd0, v); chk("R5 ptr after read", v, 8'h10);
        cread(8'h10, v); chk("R10 cop sees host byte", v, 8'hA5);
    endtask

    task automatic t_alias();
        logic [7:0] v;
        set_ptr(16'h1234);
        hwrite(2'd2, 8'h5C);
        cread(8'h34, v); chk("R3 low bits index RAM", v, 8'h5C);
    endtask

    task automatic t_autoinc();
        logic [7:0] v;
        hwrite(2'd3, 8'h14);
        chk("R6 run set", cop_run, 1);
        set_ptr(16'h0020);
        for (int i = 0; i < 4; i++) hwrite(2'd2, 8'h60 + 8'(i));
        hread(2'd0, v); chk("R4 ptr after writes", v, 8'h24);
        set_ptr(16'h0020);
        for (int i = 0; i < 4; i++) begin
            hread(2'd2, v); chk("R4 stream read", v, 8'h60 + i);
        end
        hread(2'd0, v); chk("R4 ptr after reads", v, 8'h24);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        set_ptr(16'hFFFF);
        hwrite(2'd2, 8'h77);
        hread(2'd0, v); chk("R4 wrap lo", v, 8'h00);
        hread(2'd1, v); chk("R4 wrap hi", v, 8'h00);
        cread(8'hFF, v); chk("R3 byte at 0xFFFF", v, 8'h77);
    endtask

    task automatic t_req();
        logic [7:0] v;
        hwrite(2'd3, 8'h1C);
        chk("R7 request raised", cop_irq, 1);
        hread(2'd3, v); chk("R6 ctrl layout", v, 8'h1C);
        @(negedge clk); cop_irq_ack = 1'b1;
        @(negedge clk); cop_irq_ack = 1'b0;
        chk("R7 ack clears", cop_irq, 0);
        @(negedge clk);
        host_wr = 1'b1; host_reg = 2'd3; host_wdata = 8'h1C; cop_irq_ack = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; cop_irq_ack = 1'b0;
        chk("R7 write beats ack", cop_irq, 1);
        @(negedge clk); cop_irq_ack = 1'b1;
        @(negedge clk); cop_irq_ack = 1'b0;
        chk("R7 ack after collision", cop_irq, 0);
    endtask

    task automatic t_mailbox();
        logic [7:0] v;
        @(negedge clk); cop_set_int0 = 1'b1;
        @(negedge clk); cop_set_int0 = 1'b0;
        chk("R8 line from INT0", host_irq, 1);
        @(negedge clk); cop_set_int1 = 1'b1;
        @(negedge clk); cop_set_int1 = 1'b0;
        hread(2'd3, v); chk("R8 both flags", v, 8'h17);
        hwrite(2'd3, 8'h15);
        hread(2'd3, v); chk("R9 clear INT0 only", v, 8'h16);
        chk("R8 line from INT1", host_irq, 1);
        hwrite(2'd3, 8'h14);
        hread(2'd3, v); chk("R9 zero leaves flag", v, 8'h16);
        @(negedge clk);
        host_wr = 1'b1; host_reg = 2'd3; host_wdata = 8'h16; cop_set_int1 = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; cop_set_int1 = 1'b0;
        hread(2'd3, v); chk("R9 set beats clear", v, 8'h16);
        hwrite(2'd3, 8'h16);
        hread(2'd3, v); chk("R9 clear INT1", v, 8'h14);
        chk("R8 line low", host_irq, 0);
    endtask

    task automatic t_alive();
        logic [7:0] v;
        hwrite(2'd3, 8'h04);
        cwrite(8'h40, 8'hFF);
        set_ptr(16'h0040);
        hread(2'd2, v); chk("R10 liveness seen", v, 8'hFF);
        hwrite(2'd2, 8'h00);
        cread(8'h40, v); chk("R10 liveness cleared", v, 8'h00);
        @(negedge clk);
        host_wr = 1'b1; host_reg = 2'd2; host_wdata = 8'h3C;
        cop_en = 1'b1; cop_we = 1'b1; cop_addr = 8'h40; cop_wdata = 8'hC3;
        @(negedge clk);
        host_wr = 1'b0; cop_en = 1'b0; cop_we = 1'b0;
        cread(8'h40, v); chk("R10 host wins collision", v, 8'h3C);
        hwrite(2'd3, 8'h00);
        chk("R6 run cleared", cop_run, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ptr_load();
        t_data_noinc();
        t_alias();
        t_autoinc();
        t_wrap();
        t_req();
        t_mailbox();
        t_alive();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule